// File: doc/BRIEF.md
# Serial Flash Continuous-Read Front End

This block is the device-side command and read path of a page-organised serial flash. A host talks to it over a four-wire serial link made of an active-low select, a serial clock, a data input and a data output. After select goes low, the block shifts in an 8-bit command code and a 24-bit address. It then streams bytes out for as long as the host keeps toggling the clock, with no further addressing.

Bytes come either from the main array or from one of two on-chip buffers. The block reaches them through a synchronous one-cycle read port; the storage itself lives outside the block. A page holds 528 bytes, which is not a power of two. The internal read pointer therefore wraps its byte field after offset 527 and, for the main array, carries into a 12-bit page number that wraps after page 4095.

All link pins are resampled by the block's own clock `clk`, so the serial clock runs much slower than `clk`. The serial output is paired with an enable that marks when the pad should be driven.

Top module: `sfr_read_frontend`

## Requirements
- R1: After reset, and while the select line is high, `so_oe` is 0 and `mem_rd_en` is 0.
- R2: After select falls, the first 8 bits sampled on rising serial-clock edges form the command code and the next 24 bits form the address, both MSB first; `so_oe` stays 0 for all 32 of those bits.
- R3: For a main-array read the address bits [21:10] give the start page and bits [9:0] the start byte offset; bits [23:22] have no effect on the data.
- R4: Read data leaves MSB first. Each bit changes after a falling serial-clock edge, and the first bit follows the falling edge after the last address bit. `so_oe` is 1 from that edge until select rises.
- R5: Successive bytes of one read come from successive addresses with no extra input from the host.
- R6: In a main-array read, the byte after offset 527 of page P is offset 0 of page P+1.
- R7: In a main-array read, the byte after page 4095 offset 527 is page 0 offset 0.
- R8: Command code 0x54 reads buffer 1 (`mem_src` = 1) and 0x56 reads buffer 2 (`mem_src` = 2), starting at address bits [9:0]. After offset 527 the read wraps to offset 0 of the same buffer, and `mem_page` is 0.
- R9: Command codes 0x0B and 0x1B both start a main-array read (`mem_src` = 0) and give the same bytes. Either works with the serial clock idling low (mode 0) or idling high (mode 3) while select is high.
- R10: A rise of select at any point ends the transfer. `so_oe` returns to 0 within 4 `clk` cycles, and the next command is decoded from its first bit.
- R11: Any other command code is ignored: `so_oe` stays 0 and no memory read is issued until select rises.
- R12: `mem_rd_en` is a single-cycle pulse, one per byte plus one look-ahead byte per read. `mem_rdata` is taken on the `clk` edge one cycle after the pulse. Each serial-clock phase lasts at least 6 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for the serial output pad (0 = high impedance) |
| mem_rd_en | output | 1 | One-cycle read strobe to the storage model |
| mem_src | output | 2 | Read source: 0 main array, 1 buffer 1, 2 buffer 2 |
| mem_page | output | 12 | Page number of the read |
| mem_byte | output | 10 | Byte offset of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |

## Verification
Each serial-clock edge reaches the logic three `clk` cycles after it appears on the pin: two for the synchroniser and one for edge detection. The edge then acts on the following clock edge. The first memory read issues one cycle after the last address bit is taken, and its data is held two cycles later. That is well inside the eight-cycle clock phases the bench drives, so it reads `so` just before each rising edge, two nanoseconds away from any `clk` edge. Abort behaviour is checked five `clk` cycles after select rises, which allows for the three-cycle synchroniser path. Read-strobe counts are compared only after the whole frame has ended.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_ARRAY_A = 8'h0B;
  localparam logic [OPC_W-1:0] OPC_ARRAY_B = 8'h1B;
  localparam logic [OPC_W-1:0] OPC_BUF_1   = 8'h54;
  localparam logic [OPC_W-1:0] OPC_BUF_2   = 8'h56;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_BUF1  = 2'd1,
    SRC_BUF2  = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_IGNORE
  } phase_e;
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  output logic cs_hi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic si_s
);
  localparam int NPINS = 3;
  localparam logic [NPINS-1:0] RST_VAL = 3'b100;

  logic [NPINS-1:0] pin_in;
  logic [NPINS-1:0] pin_s;
  logic             sclk_prev_q;

  assign pin_in = {cs_n, sclk, si};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], pin_in[g]};
    end
    assign pin_s[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= pin_s[1];
  end

  assign cs_hi     = pin_s[2];
  assign sclk_rise = pin_s[1] & ~sclk_prev_q;
  assign sclk_fall = ~pin_s[1] & sclk_prev_q;
  assign si_s      = pin_s[0];
endmodule

// File: rtl/sfr_cmd_decode.sv
module sfr_cmd_decode
  import sfr_pkg::*;
#(
  parameter int ADDR_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_hi,
  input  logic                 sclk_rise,
  input  logic                 si_s,
  output phase_e               phase,
  output src_e                 src,
  output logic                 load,
  output logic [ADDR_BITS-1:0] load_addr
);
  localparam int CNT_W = $clog2(ADDR_BITS);

  phase_e               state_q, state_d;
  src_e                 src_q, src_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [ADDR_BITS-1:0] sh_q, sh_d;
  logic [OPC_W-1:0]     opc_w;

  assign opc_w     = {sh_q[OPC_W-2:0], si_s};
  assign load_addr = {sh_q[ADDR_BITS-2:0], si_s};

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    load    = 1'b0;
    if (cs_hi) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (sclk_rise) begin
      case (state_q)
        ST_IDLE, ST_OPC: begin
          state_d = ST_OPC;
          sh_d    = load_addr;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(OPC_W - 1)) begin
            cnt_d = '0;
            sh_d  = '0;
            case (opc_w)
              OPC_ARRAY_A, OPC_ARRAY_B: begin state_d = ST_ADDR; src_d = SRC_ARRAY; end
              OPC_BUF_1:                begin state_d = ST_ADDR; src_d = SRC_BUF1;  end
              OPC_BUF_2:                begin state_d = ST_ADDR; src_d = SRC_BUF2;  end
              default:                  state_d = ST_IGNORE;
            endcase
          end
        end
        ST_ADDR: begin
          sh_d  = load_addr;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
            load    = 1'b1;
            state_d = ST_DATA;
            cnt_d   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_ARRAY;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  assign phase = state_q;
  assign src   = src_q;

  // R2: a load only ever ends the address phase
  a_r2_load_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (state_q == ST_ADDR));
  // R11: an ignored command never reaches the address phase before select rises
  a_r11_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE && !cs_hi) |=> (state_q == ST_IGNORE));
endmodule

// File: rtl/sfr_addr_ctr.sv
module sfr_addr_ctr
  import sfr_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int BYTE_BITS = 10,
  parameter int PAGE_SIZE = 528
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  src_e                 load_src,
  input  logic [PAGE_BITS-1:0] load_page,
  input  logic [BYTE_BITS-1:0] load_byte,
  input  logic                 step,
  output logic [PAGE_BITS-1:0] page_q,
  output logic [BYTE_BITS-1:0] byte_q
);
  localparam logic [BYTE_BITS-1:0] LAST_BYTE = BYTE_BITS'(PAGE_SIZE - 1);

  logic [PAGE_BITS-1:0] page_d;
  logic [BYTE_BITS-1:0] byte_d;
  logic                 is_array_q;
  logic                 byte_wrap;

  if (PAGE_SIZE == (1 << BYTE_BITS)) begin : g_pow2
    assign byte_wrap = &byte_q;
  end else begin : g_odd
    assign byte_wrap = (byte_q >= LAST_BYTE);
  end

  always_comb begin
    page_d = page_q;
    byte_d = byte_q;
    if (load) begin
      page_d = (load_src == SRC_ARRAY) ? load_page : '0;
      byte_d = load_byte;
    end else if (step) begin
      if (byte_wrap) begin
        byte_d = '0;
        if (is_array_q) page_d = page_q + 1'b1;
      end else begin
        byte_d = byte_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      byte_q     <= '0;
      is_array_q <= 1'b1;
    end else begin
      page_q <= page_d;
      byte_q <= byte_d;
      if (load) is_array_q <= (load_src == SRC_ARRAY);
    end
  end

  // R6 / R7: array wrap at the last byte carries into the page field
  a_r6_page_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && is_array_q && byte_q == LAST_BYTE)
      |=> (byte_q == '0 && page_q == PAGE_BITS'($past(page_q) + 1'b1)));
  // R8: buffer reads never move the page field
  a_r8_buf_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !is_array_q) |=> $stable(page_q));
endmodule

// File: rtl/sfr_out_shift.sv
module sfr_out_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              in_data,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              next_rd,
  output logic              so,
  output logic              so_oe
);
  localparam int FC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [FC_W-1:0]   fcnt_q, fcnt_d;
  logic              oe_q, oe_d;

  assign next_rd = sclk_rise & in_data & oe_q & (fcnt_q == '0) & ~cs_hi;

  always_comb begin
    hold_d = rd_done ? rd_data : hold_q;
    sh_d   = sh_q;
    fcnt_d = fcnt_q;
    oe_d   = oe_q;
    if (cs_hi) begin
      fcnt_d = '0;
      oe_d   = 1'b0;
    end else if (sclk_fall && in_data) begin
      oe_d   = 1'b1;
      fcnt_d = fcnt_q + 1'b1;
      if (fcnt_q == '0) sh_d = hold_q;
      else              sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      fcnt_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      fcnt_q <= fcnt_d;
      oe_q   <= oe_d;
    end
  end

  assign so    = sh_q[DATA_W-1];
  assign so_oe = oe_q;

  // R4: a falling edge in the data phase turns the output on
  a_r4_fall_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && in_data && !cs_hi) |=> so_oe);
  // R4: the output bit only moves on a falling edge
  a_r4_bit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_hi) |=> $stable(sh_q));
endmodule

// File: rtl/sfr_read_frontend.sv
module sfr_read_frontend
  import sfr_pkg::*;
#(
  parameter int PAGE_BITS   = 12,
  parameter int BYTE_BITS   = 10,
  parameter int PAGE_SIZE   = 528,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 si,
  output logic                 so,
  output logic                 so_oe,
  output logic                 mem_rd_en,
  output logic [1:0]           mem_src,
  output logic [PAGE_BITS-1:0] mem_page,
  output logic [BYTE_BITS-1:0] mem_byte,
  input  logic [DATA_W-1:0]    mem_rdata
);
  localparam int ADDR_BITS = 24;
  localparam int USED_BITS = PAGE_BITS + BYTE_BITS;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 cs_hi, sclk_rise, sclk_fall, si_s;
  phase_e               phase;
  src_e                 src;
  logic                 load;
  logic [ADDR_BITS-1:0] load_addr;
  logic                 first_rd_q;
  logic                 next_rd;
  logic                 rd_req;
  logic                 rd_done_q;
  logic                 unused_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .cs_hi(cs_hi), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si_s(si_s)
  );

  sfr_cmd_decode #(.ADDR_BITS(ADDR_BITS)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .cs_hi(cs_hi), .sclk_rise(sclk_rise),
    .si_s(si_s), .phase(phase), .src(src), .load(load), .load_addr(load_addr)
  );

  assign unused_hi = ^load_addr[ADDR_BITS-1:USED_BITS];

  sfr_addr_ctr #(
    .PAGE_BITS(PAGE_BITS), .BYTE_BITS(BYTE_BITS), .PAGE_SIZE(PAGE_SIZE)
  ) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .load(load), .load_src(src),
    .load_page(load_addr[USED_BITS-1:BYTE_BITS]),
    .load_byte(load_addr[BYTE_BITS-1:0]),
    .step(rd_req), .page_q(mem_page), .byte_q(mem_byte)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      first_rd_q <= 1'b0;
      rd_done_q  <= 1'b0;
    end else begin
      first_rd_q <= load & ~cs_hi;
      rd_done_q  <= rd_req;
    end
  end

  assign rd_req    = (first_rd_q | next_rd) & ~cs_hi;
  assign mem_rd_en = rd_req;
  assign mem_src   = src;

  sfr_out_shift #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .cs_hi(cs_hi), .in_data(phase == ST_DATA),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_done(rd_done_q),
    .rd_data(mem_rdata), .next_rd(next_rd), .so(so), .so_oe(so_oe)
  );

  // R1 / R10: a high select seen by the logic clears the drive enable
  a_r10_abort_hiz: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_hi |=> !so_oe);
  // R2: no drive during command code or address
  a_r2_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == ST_OPC || phase == ST_ADDR) |-> !so_oe);
  // R11: an ignored command produces neither output nor reads
  a_r11_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == ST_IGNORE) |-> (!so_oe && !mem_rd_en));
  // R12: read strobes are single-cycle pulses
  a_r12_rd_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd_en |=> !mem_rd_en);
  // R12: reads happen only in the data phase
  a_r12_rd_in_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd_en |-> (phase == ST_DATA));
endmodule

// File: tb/tb_sfr_read_frontend.sv
module tb_sfr_read_frontend;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sclk, si;
  logic        so, so_oe, mem_rd_en;
  logic [1:0]  mem_src;
  logic [11:0] mem_page;
  logic [9:0]  mem_byte;
  logic [7:0]  mem_rdata;
  logic        cpol;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  sfr_read_frontend dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .so(so), .so_oe(so_oe), .mem_rd_en(mem_rd_en), .mem_src(mem_src),
    .mem_page(mem_page), .mem_byte(mem_byte), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_val(input logic [1:0] s, input logic [11:0] p,
                                         input logic [9:0] b);
    return b[7:0] ^ {p[3:0], p[11:8]} ^ {s, 6'd0} ^ {6'd0, b[9:8]};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem_val(mem_src, mem_page, mem_byte);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(posedge clk);
    #2;
  endtask

  task automatic cs_start();
    sclk = cpol;
    half();
    cs_n = 1'b0;
    half();
  endtask

  task automatic cs_end();
    sclk = cpol;
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r,
                      output logic any_oe, output logic all_oe);
    r = '0; any_oe = 1'b0; all_oe = 1'b1;
    for (int i = 7; i > 7 - nb; i--) begin
      sclk = 1'b0;
      si   = b[i];
      half();
      r[i]   = so;
      any_oe = any_oe | so_oe;
      all_oe = all_oe & so_oe;
      sclk = 1'b1;
      half();
    end
  endtask

  task automatic send_cmd(input logic [7:0] opc, input logic [23:0] addr, output logic cmd_oe);
    logic [7:0] r;
    logic a, al;
    cmd_oe = 1'b0;
    xfer(opc, 8, r, a, al);          cmd_oe |= a;
    xfer(addr[23:16], 8, r, a, al);  cmd_oe |= a;
    xfer(addr[15:8], 8, r, a, al);   cmd_oe |= a;
    xfer(addr[7:0], 8, r, a, al);    cmd_oe |= a;
  endtask

  // driver: pushes the expected stream, then clocks the frame
  task automatic run_read(input logic [7:0] opc, input logic [23:0] addr, input int n,
                          input logic [1:0] s, input string tag);
    logic [11:0] pg;
    logic [9:0]  by;
    logic [7:0]  r;
    logic        a, al, cmd_oe, oe_bad;
    int          rd0;
    pg = (s == 2'd0) ? addr[21:10] : 12'd0;
    by = addr[9:0];
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mem_val(s, pg, by));
      tag_q.push_back(tag);
      if (by == 10'd527) begin
        by = '0;
        if (s == 2'd0) pg = pg + 1'b1;
      end else begin
        by = by + 1'b1;
      end
    end
    rd0 = rd_cnt;
    oe_bad = 1'b0;
    cs_start();
    send_cmd(opc, addr, cmd_oe);
    check(!cmd_oe, "R2 output quiet during command", cmd_oe, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r, a, al);
      rx_q.push_back(r);
      if (!al) oe_bad = 1'b1;
    end
    check(!oe_bad, "R4 output driven through data", oe_bad, 0);
    cs_end();
    check(rd_cnt - rd0 == n + 1, "R12 read strobe count", rd_cnt - rd0, n + 1);
  endtask

  // monitor: pops and compares results as they arrive
  initial begin
    forever begin
      logic [7:0] act, exp;
      string t;
      wait (rx_q.size() != 0);
      act = rx_q.pop_front();
      exp = exp_q.pop_front();
      t   = tag_q.pop_front();
      check(act == exp, t, act, exp);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic a, al, cmd_oe, any;
    int rd0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; si = 1'b0; cpol = 1'b0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #2;
    check(so_oe == 1'b0, "R1 reset drive enable", so_oe, 0);
    check(mem_rd_en == 1'b0, "R1 reset read strobe", mem_rd_en, 0);

    // R3 R5: mode 0, upper address bits set
    run_read(8'h0B, {2'b11, 12'd5, 10'd100}, 6, 2'd0, "R3 R5 array stream");
    // R9: other opcode, mode 3, same start
    cpol = 1'b1;
    run_read(8'h1B, {2'b00, 12'd5, 10'd100}, 3, 2'd0, "R9 mode 3 alt opcode");
    cpol = 1'b0;
    // R6: page carry
    run_read(8'h0B, {2'b00, 12'd7, 10'd526}, 4, 2'd0, "R6 page carry");
    // R7: last page wraps
    cpol = 1'b1;
    run_read(8'h0B, {2'b01, 12'd4095, 10'd527}, 3, 2'd0, "R7 page wrap");
    cpol = 1'b0;
    // R8: buffers
    run_read(8'h54, {14'h2A5A, 10'd525}, 4, 2'd1, "R8 buffer 1 wrap");
    cpol = 1'b1;
    run_read(8'h56, {14'h0001, 10'd0}, 2, 2'd2, "R8 buffer 2");
    cpol = 1'b0;

    // R11: unknown opcode
    rd0 = rd_cnt;
    any = 1'b0;
    cs_start();
    xfer(8'hA5, 8, r, a, al); any |= a;
    for (int k = 0; k < 4; k++) begin
      xfer(8'h0B, 8, r, a, al);
      any |= a;
    end
    cs_end();
    check(!any, "R11 unknown opcode keeps output off", any, 0);
    check(rd_cnt == rd0, "R11 unknown opcode issues no reads", rd_cnt - rd0, 0);

    // R10: abort in the address, then a clean command
    cs_start();
    xfer(8'h0B, 8, r, a, al);
    xfer(8'hFF, 8, r, a, al);
    xfer(8'hF0, 4, r, a, al);
    cs_end();
    run_read(8'h0B, {2'b00, 12'd3, 10'd10}, 2, 2'd0, "R10 decode after abort");

    // R10: abort in the data phase
    cs_start();
    send_cmd(8'h0B, {2'b00, 12'd9, 10'd0}, cmd_oe);
    xfer(8'h00, 8, r, a, al);
    sclk = 1'b0;
    half();
    check(so_oe == 1'b1, "R4 drive before abort", so_oe, 1);
    cs_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    check(so_oe == 1'b0, "R10 abort releases output", so_oe, 0);
    half();
    half();

    wait (rx_q.size() == 0);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule